// File: doc/BRIEF.md
# Two-Tone FSK Tag Waveform Generator

This block turns a 44-bit tag identifier into a repeating one-bit load-modulation stream for a low-frequency tag simulator. It emits one sample for each simulator sample enable. The stream is built from two subcarrier groups. The fast group has a period of 8 samples and the slow group has a period of 10 samples. Every identifier bit becomes an ordered pair of these groups. Each frame starts with a marker made of group pairs that are not valid bit symbols. An extra fast group is placed ahead of every four identifier bits.

A start request latches the identifier and begins transmission at the marker. The frame then repeats back to back until a stop request is seen. The stop takes effect at the end of the frame that is in progress. The block also flags the first sample of every frame so that a capture or trigger circuit can align to it.

Top module: `fsk_tag_wavegen`

## Requirements
- R1: A fast group is 48 samples: the 8-sample pattern 1,1,0,0,0,0,0,0 sent six times.
- R2: A slow group is 50 samples: the 10-sample pattern 1,1,1,0,0,0,0,0,0,0 sent five times.
- R3: An identifier bit of value 1 is sent as a fast group followed by a slow group. A bit of value 0 is sent as a slow group followed by a fast group.
- R4: Every frame opens with eight groups in the order fast, fast, fast, slow, slow, slow, fast, slow.
- R5: Identifier bits go out from bit 43 down to bit 0. One extra fast group comes before bits 43, 39, 35 and so on down to bit 3, which gives 11 separator groups and a frame length of 5232 samples.
- R6: A start request is rejected when any bit of `id_in` above bit 43 is set. In that case the output stays low and no frame begins.
- R7: After the last group of bit 0, the next sample is the first marker sample, with no gap between frames.
- R8: A stop request received during a frame lets that frame finish. From the next sample on, `mod_out` and `frame_start` stay low until a new start is accepted.
- R9: `frame_start` is high exactly while the first sample of a marker is presented, which is one sample enable per frame.
- R10: While reset is active, and after it is released, `mod_out` and `frame_start` are low.
- R11: Samples advance only on cycles where `smp_en` is high. On all other cycles both outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_en | input | 1 | Advance to the next waveform sample |
| start | input | 1 | Begin transmitting `id_in`; only acts while idle |
| stop | input | 1 | Request a halt at the next frame boundary |
| id_in | input | IN_W (64) | Identifier; bits 43..0 are sent, and any higher bit set rejects the start |
| mod_out | output | 1 | Load-modulation sample |
| frame_start | output | 1 | High on the first sample of each frame |

## Verification
The bound checker watches, on every cycle, the properties that hold locally. Outputs hold when no sample enable arrives. The frame flag lasts one enabled sample and always coincides with a high sample. A wide identifier never starts a frame, a valid start immediately presents the flagged first sample, and an idle block stays idle without a start. The shape of the groups, the marker order, the bit order, the placement of the separators, back-to-back repetition and the stop timing all depend on the full sample sequence. Only the bench shows these, by comparing every sample over whole frames against an arithmetic model. It uses several identifiers, both continuous and irregular sample enables, and a stop issued partway through a frame.

// File: rtl/fsk_wave_pkg.sv
package fsk_wave_pkg;
  // Which subcarrier group is being emitted
  typedef enum logic {
    GRP_FC10 = 1'b0,
    GRP_FC8  = 1'b1
  } grp_e;
endpackage

// File: rtl/fsk_subcarrier.sv
// Produces the samples of one subcarrier group and flags its first and last sample.
module fsk_subcarrier
  import fsk_wave_pkg::*;
#(
  parameter int A_DIV = 8,
  parameter int A_HI  = 2,
  parameter int A_REP = 6,
  parameter int B_DIV = 10,
  parameter int B_HI  = 3,
  parameter int B_REP = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  input  grp_e sel,
  output logic smp,
  output logic grp_head,
  output logic grp_end
);
  localparam int MAXD = (A_DIV > B_DIV) ? A_DIV : B_DIV;
  localparam int MAXR = (A_REP > B_REP) ? A_REP : B_REP;
  localparam int PW   = (MAXD > 2) ? $clog2(MAXD) : 1;
  localparam int RW   = (MAXR > 2) ? $clog2(MAXR) : 1;

  logic [PW-1:0] ph_q, ph_d, ph_lim, ph_hi;
  logic [RW-1:0] rep_q, rep_d, rep_lim;

  always_comb begin
    if (sel == GRP_FC8) begin
      ph_lim  = PW'(A_DIV - 1);
      ph_hi   = PW'(A_HI);
      rep_lim = RW'(A_REP - 1);
    end else begin
      ph_lim  = PW'(B_DIV - 1);
      ph_hi   = PW'(B_HI);
      rep_lim = RW'(B_REP - 1);
    end
  end

  assign smp      = (ph_q < ph_hi);
  assign grp_head = (ph_q == '0) && (rep_q == '0);
  assign grp_end  = (ph_q == ph_lim) && (rep_q == rep_lim);

  always_comb begin
    ph_d  = ph_q;
    rep_d = rep_q;
    if (clr) begin
      ph_d  = '0;
      rep_d = '0;
    end else if (ph_q == ph_lim) begin
      ph_d  = '0;
      rep_d = grp_end ? '0 : rep_q + RW'(1);
    end else begin
      ph_d = ph_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      rep_q <= '0;
    end else if (clr || adv) begin
      ph_q  <= ph_d;
      rep_q <= rep_d;
    end
  end
endmodule

// File: rtl/fsk_framer.sv
// Walks the group order of a frame: marker, then separator plus bit pairs per nibble.
module fsk_framer
  import fsk_wave_pkg::*;
#(
  parameter int ID_BITS = 44,
  parameter int NIB     = 4,
  parameter int MARK_N  = 8,
  parameter logic [MARK_N-1:0] MARK_SEQ = 8'b0100_0111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [ID_BITS-1:0] id_src,
  output grp_e               grp,
  output logic               head,
  output logic               last_grp
);
  localparam int NIBS  = ID_BITS / NIB;
  localparam int SLOTS = 2 * NIB + 1;
  localparam int MW    = (MARK_N > 2) ? $clog2(MARK_N) : 1;
  localparam int SW    = $clog2(SLOTS);
  localparam int NW    = (NIBS > 2) ? $clog2(NIBS) : 1;

  logic               in_mark_q, in_mark_d;
  logic [MW-1:0]      mk_q, mk_d;
  logic [SW-1:0]      pos_q, pos_d;
  logic [NW-1:0]      nib_q, nib_d;
  logic [ID_BITS-1:0] sh_q, sh_d;

  always_comb begin
    if (in_mark_q)           grp = grp_e'(MARK_SEQ[mk_q]);
    else if (pos_q == '0)    grp = GRP_FC8;
    else                     grp = grp_e'(sh_q[ID_BITS-1] ^ ~pos_q[0]);
  end

  assign head     = in_mark_q && (mk_q == '0);
  assign last_grp = !in_mark_q && (nib_q == NW'(NIBS - 1)) && (pos_q == SW'(SLOTS - 1));

  always_comb begin
    in_mark_d = in_mark_q;
    mk_d      = mk_q;
    pos_d     = pos_q;
    nib_d     = nib_q;
    sh_d      = sh_q;
    if (load) begin
      in_mark_d = 1'b1;
      mk_d      = '0;
      pos_d     = '0;
      nib_d     = '0;
      sh_d      = id_src;
    end else if (in_mark_q) begin
      if (mk_q == MW'(MARK_N - 1)) begin
        in_mark_d = 1'b0;
        pos_d     = '0;
        nib_d     = '0;
      end else begin
        mk_d = mk_q + MW'(1);
      end
    end else begin
      if (pos_q != '0 && !pos_q[0]) sh_d = {sh_q[ID_BITS-2:0], 1'b0};
      if (pos_q == SW'(SLOTS - 1)) begin
        pos_d = '0;
        if (nib_q == NW'(NIBS - 1)) begin
          in_mark_d = 1'b1;
          mk_d      = '0;
          nib_d     = '0;
          sh_d      = id_src;
        end else begin
          nib_d = nib_q + NW'(1);
        end
      end else begin
        pos_d = pos_q + SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_mark_q <= 1'b1;
      mk_q      <= '0;
      pos_q     <= '0;
      nib_q     <= '0;
      sh_q      <= '0;
    end else if (load || step) begin
      in_mark_q <= in_mark_d;
      mk_q      <= mk_d;
      pos_q     <= pos_d;
      nib_q     <= nib_d;
      sh_q      <= sh_d;
    end
  end
endmodule

// File: rtl/fsk_tag_wavegen.sv
module fsk_tag_wavegen
  import fsk_wave_pkg::*;
#(
  parameter int IN_W    = 64,
  parameter int ID_BITS = 44,
  parameter int NIB     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_en,
  input  logic            start,
  input  logic            stop,
  input  logic [IN_W-1:0] id_in,
  output logic            mod_out,
  output logic            frame_start
);
  logic [1:0]         rs_q;
  logic               core_rst_n;
  logic               id_ok, accept, adv, step, frame_end;
  logic               active_q, active_d, stop_q, stop_d;
  logic [ID_BITS-1:0] id_q, id_d, id_src;
  grp_e               grp;
  logic               smp, grp_head, grp_end, head, last_grp;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  generate
    if (IN_W > ID_BITS) begin : g_wide
      assign id_ok = ~|id_in[IN_W-1:ID_BITS];
    end else begin : g_exact
      assign id_ok = 1'b1;
    end
  endgenerate

  assign accept    = !active_q && start && id_ok;
  assign adv       = active_q && smp_en;
  assign step      = adv && grp_end;
  assign frame_end = step && last_grp;
  assign id_src    = accept ? id_in[ID_BITS-1:0] : id_q;

  always_comb begin
    active_d = active_q;
    stop_d   = stop_q;
    id_d     = id_q;
    if (accept) begin
      active_d = 1'b1;
      stop_d   = 1'b0;
      id_d     = id_in[ID_BITS-1:0];
    end else if (active_q) begin
      if (frame_end) begin
        active_d = !(stop_q || stop);
        stop_d   = 1'b0;
      end else begin
        stop_d = stop_q || stop;
      end
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      active_q <= 1'b0;
      stop_q   <= 1'b0;
      id_q     <= '0;
    end else begin
      active_q <= active_d;
      stop_q   <= stop_d;
      if (accept) id_q <= id_d;
    end
  end

  fsk_subcarrier u_sub (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .clr      (accept),
    .adv      (adv),
    .sel      (grp),
    .smp      (smp),
    .grp_head (grp_head),
    .grp_end  (grp_end)
  );

  fsk_framer #(.ID_BITS(ID_BITS), .NIB(NIB)) u_frm (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .load     (accept),
    .step     (step),
    .id_src   (id_src),
    .grp      (grp),
    .head     (head),
    .last_grp (last_grp)
  );

  assign mod_out     = active_q && smp;
  assign frame_start = active_q && head && grp_head;
endmodule

// File: rtl/fsk_tag_wavegen_chk.sv
module fsk_tag_wavegen_chk #(
  parameter int IN_W    = 64,
  parameter int ID_BITS = 44
) (
  input logic            clk,
  input logic            rst_n,
  input logic            smp_en,
  input logic            start,
  input logic [IN_W-1:0] id_in,
  input logic            active,
  input logic            mod_out,
  input logic            frame_start
);
  logic wide;
  assign wide = (id_in >> ID_BITS) != '0;

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && !smp_en |=> $stable(mod_out) && $stable(frame_start));

  // R9
  flag_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && smp_en |=> !frame_start);

  // R9
  flag_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> mod_out);

  // R6
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active && start && wide |=> !active);

  // R9
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active && start && !wide && $past(rst_n) |=> active && frame_start);

  // R8
  stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !start |=> !active && !mod_out);
endmodule

bind fsk_tag_wavegen fsk_tag_wavegen_chk #(.IN_W(IN_W), .ID_BITS(ID_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (core_rst_n),
  .smp_en      (smp_en),
  .start       (start),
  .id_in       (id_in),
  .active      (active_q),
  .mod_out     (mod_out),
  .frame_start (frame_start)
);

// File: tb/sim_fsk_tag_wavegen.sv
module sim_fsk_tag_wavegen;
  localparam int CLK_P = 10;
  localparam int FL    = 4*48 + 4*50 + 11*48 + 44*(48+50);
  localparam int NB    = 10;

  logic        clk, rst_n, smp_en, start, stop;
  logic [63:0] id_in;
  logic        mod_out, frame_start;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int    mm [NB];
  int    ncnt [NB];
  int    fa [NB];
  int    fe [NB];
  int    fk [NB];
  string rq [NB] = '{"R1", "R2", "R4", "R5", "R3", "R7", "R9", "R8", "R6", "R11"};

  fsk_tag_wavegen u0 (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .start(start), .stop(stop),
    .id_in(id_in), .mod_out(mod_out), .frame_start(frame_start)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // group type of group g: 1 = fast (period 8), 0 = slow (period 10)
  function automatic bit gtype(input logic [43:0] id, input int g);
    bit mark [8] = '{1, 1, 1, 0, 0, 0, 1, 0};
    int r, nib, pos, b;
    if (g < 8) return mark[g];
    r   = g - 8;
    nib = r / 9;
    pos = r % 9;
    if (pos == 0) return 1'b1;
    b = 43 - (nib*4 + (pos-1)/2);
    return ((pos-1) % 2 == 0) ? id[b] : !id[b];
  endfunction

  function automatic void locate(input logic [43:0] id, input int kk, output int g, output int j);
    int rem, len;
    rem = kk;
    g = 0;
    len = gtype(id, 0) ? 48 : 50;
    while (rem >= len) begin
      rem = rem - len;
      g = g + 1;
      len = gtype(id, g) ? 48 : 50;
    end
    j = rem;
  endfunction

  task automatic note(input int b, input int k, input int act, input int ex);
    ncnt[b]++;
    if (act != ex) begin
      if (mm[b] == 0) begin
        fa[b] = act; fe[b] = ex; fk[b] = k;
      end
      mm[b]++;
    end
  endtask

  task automatic report(input string name);
    for (int b = 0; b < NB; b++) begin
      if (ncnt[b] > 0) begin
        checks++;
        if (mm[b] > 0) begin
          errors++;
          $display("FAIL %s %s: sample %0d got %0d expected %0d (%0d mismatches)",
                   rq[b], name, fk[b], fa[b], fe[b], mm[b]);
        end
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; smp_en = 1'b1; start = 1'b0; stop = 1'b0; id_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // start with id, then follow nsamp samples against the model
  task automatic run_case(input logic [63:0] id, input int nsamp, input bit gaps,
                          input int stop_k, input bit rej, input string name);
    int k, g, j, sb, kf, b;
    bit ex, en;
    logic [15:0] lf;
    lf = 16'hACE1;
    for (int i = 0; i < NB; i++) begin mm[i] = 0; ncnt[i] = 0; end
    sb = (stop_k >= 0) ? ((stop_k / FL) + 1) * FL : 32'h7fffffff;
    @(negedge clk);
    id_in = id; start = 1'b1; smp_en = 1'b0; stop = 1'b0;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (k < nsamp) begin
      if (rej) begin
        note(8, k, mod_out, 0);
        note(8, k, frame_start, 0);
      end else if (k >= sb) begin
        note(7, k, mod_out, 0);
        note(7, k, frame_start, 0);
      end else begin
        kf = k % FL;
        locate(id[43:0], kf, g, j);
        ex = gtype(id[43:0], g) ? ((j % 8) < 2) : ((j % 10) < 3);
        if (k >= FL)                          b = 5;
        else if (g == 0)                      b = 0;
        else if (g == 3)                      b = 1;
        else if (g < 8)                       b = 2;
        else if (((g - 8) % 9) == 0)          b = 3;
        else                                  b = 4;
        note(b, k, mod_out, ex);
        if (gaps) note(9, k, mod_out, ex);
        note(6, k, frame_start, (kf == 0));
      end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      en = gaps ? (lf[0] | lf[3]) : 1'b1;
      smp_en = en;
      stop = (k == stop_k);
      @(negedge clk);
      if (en) k++;
    end
    smp_en = 1'b0;
    stop = 1'b0;
    report(name);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    rst_n = 1'b0; smp_en = 1'b1; start = 1'b0; stop = 1'b0; id_in = '0;
    @(negedge clk);
    checks++;
    if (mod_out !== 1'b0 || frame_start !== 1'b0) begin
      errors++;
      $display("FAIL R10 in reset: got %b%b expected 00", mod_out, frame_start);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (mod_out !== 1'b0 || frame_start !== 1'b0) begin
      errors++;
      $display("FAIL R10 after release: got %b%b expected 00", mod_out, frame_start);
    end

    // R6: wide identifier rejected
    run_case(64'h0000_1000_0000_0001, 300, 1'b0, -1, 1'b1, "bit44 set");
    run_case(64'h8000_0000_0000_0000, 100, 1'b0, -1, 1'b1, "bit63 set");

    // R1 R2 R3 R4 R5 R7 R9: two back-to-back frames
    do_reset();
    run_case(64'h0000_0A5C_31F0_E9B7, 2*FL, 1'b0, -1, 1'b0, "mixed id");
    do_reset();
    run_case(64'h0000_0000_0000_0000, FL, 1'b0, -1, 1'b0, "all zero");
    do_reset();
    run_case(64'h0000_0FFF_FFFF_FFFF, FL, 1'b0, -1, 1'b0, "all ones");
    do_reset();
    run_case(64'h0000_0800_0000_0001, FL + 10, 1'b0, -1, 1'b0, "msb and lsb");

    // R11: irregular sample enables
    do_reset();
    run_case(64'h0000_0369_CF25_8BE1, FL + 60, 1'b1, -1, 1'b0, "sparse enable");

    // R8: stop mid frame, then a fresh start
    do_reset();
    run_case(64'h0000_0123_4567_89AB, FL + 300, 1'b0, 1000, 1'b0, "stop mid frame");
    run_case(64'h0000_0FED_CBA9_8765, 500, 1'b0, -1, 1'b0, "restart after stop");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule